// File: doc/BRIEF.md
# Ringing Cadence Controller

This block sets the rhythm of ringing on one subscriber line channel. Software commands a linefeed state on a 3-bit input. When that command is the ringing code, the block keeps an internal shadow of the real line state. It moves that shadow back and forth between ringing bursts and silent gaps. During a gap the line is held in on-hook transmission. A burst ends when the burst timer runs out, and a gap ends when the gap timer runs out. Each timer is 16 bits wide and is assembled from a high byte and a low byte. The downstream line driver and waveform generator read the shadow state and a flag that reports whether a ringing waveform should be present.

Timers advance only on a tick strobe. A timer loaded with value N lasts N+1 ticks. Each timer has a run enable and an expiry pending bit, and each pending bit has its own interrupt enable. A ring-trip pulse during a burst ends the ringing: the line goes to forward active and stays there until software issues a different command.

Top module: `ring_cadence_ctrl`

## Requirements
- R1: After reset, `lf_shadow` is 000, and `ring_on`, both pending bits and `irq` are 0.
- R2: When `lf_cmd` holds any code other than ringing (100), `lf_shadow` equals that code one clock later. This includes forward active 001, on-hook transmission 010, reverse active 101 and reverse on-hook transmission 110.
- R3: When `lf_cmd` changes to 100, the next clock starts a burst. `lf_shadow` becomes 100, `ring_on` becomes 1, and the burst timer is loaded with {`act_hi`,`act_lo`}.
- R4: In a burst with `act_run_en` set, the burst ends after value+1 ticks. `lf_shadow` becomes 010, `ring_on` becomes 0, and the gap timer is loaded with {`inact_hi`,`inact_lo`}.
- R5: In a gap with `inact_run_en` set, the gap ends after value+1 ticks. A new burst then starts with the burst timer reloaded, so the cadence repeats for as long as both enables stay set and `lf_cmd` stays 100.
- R6: With `act_run_en` clear, a burst never ends, so ringing is continuous. With `inact_run_en` clear, a gap never ends.
- R7: Timers count only in cycles where `tick` is 1. Cycles without a tick do not change when a phase ends.
- R8: A burst-timer expiry sets `act_pend` only if `act_irq_en` is 1. A gap-timer expiry sets `inact_pend` only if `inact_irq_en` is 1. A pending bit stays set until its clear input is pulsed, and a set in the same cycle wins over a clear. `irq` is the OR of the two pending bits.
- R9: A `ring_trip` pulse during a burst makes `lf_shadow` 001 and `ring_on` 0 on the next clock. Both timers then stop until `lf_cmd` leaves 100. A `ring_trip` pulse during a gap is ignored.
- R10: If `lf_cmd` changes away from 100 in the middle of a cadence, `lf_shadow` takes the new code one clock later and the cadence stops.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lf_cmd | input | 3 | Commanded linefeed state |
| tick | input | 1 | Timer tick strobe |
| act_hi | input | 8 | Burst timer, high byte |
| act_lo | input | 8 | Burst timer, low byte |
| inact_hi | input | 8 | Gap timer, high byte |
| inact_lo | input | 8 | Gap timer, low byte |
| act_run_en | input | 1 | Burst timer run enable |
| inact_run_en | input | 1 | Gap timer run enable |
| act_irq_en | input | 1 | Burst expiry pending enable |
| inact_irq_en | input | 1 | Gap expiry pending enable |
| act_pend_clr | input | 1 | Clear pulse for `act_pend` |
| inact_pend_clr | input | 1 | Clear pulse for `inact_pend` |
| ring_trip | input | 1 | Ring-trip detection pulse |
| lf_shadow | output | 3 | Actual linefeed state |
| ring_on | output | 1 | Ringing waveform present |
| act_pend | output | 1 | Burst expiry pending |
| inact_pend | output | 1 | Gap expiry pending |
| irq | output | 1 | Interrupt request |

## Verification
Several properties are checked on every cycle:
- a non-ringing command is copied to the shadow one clock later;
- the waveform flag is never raised unless the shadow shows ringing;
- a trip during a burst lands on forward active;
- the counter never moves without a tick;
- a pending bit only rises after a matching set.

The following can only be shown by the bench's scenarios, which compare the outputs against a behavioural model on every clock:
- the exact phase lengths for value+1 ticks, including a high-byte value and sparse ticks;
- continuous ringing with an enable cleared;
- ignoring a trip during a gap;
- an abort in the middle of a cadence.

// File: rtl/rc_pkg.sv
package rc_pkg;
  localparam int LF_W = 3;

  localparam logic [LF_W-1:0] LF_OPEN   = 3'b000;
  localparam logic [LF_W-1:0] LF_ACTIVE = 3'b001;
  localparam logic [LF_W-1:0] LF_OHT    = 3'b010;
  localparam logic [LF_W-1:0] LF_RING   = 3'b100;

  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_BURST = 2'd1,
    PH_GAP   = 2'd2,
    PH_TRIP  = 2'd3
  } phase_e;
endpackage

// File: rtl/rc_timer.sv
module rc_timer #(
  parameter int TW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [TW-1:0] load_val,
  input  logic          run,
  output logic          expire
);
  logic [TW-1:0] cnt_q, cnt_d;
  logic          zero;

  assign zero   = (cnt_q == '0);
  assign expire = run & zero;

  always_comb begin
    cnt_d = cnt_q;
    if (load)
      cnt_d = load_val;
    else if (run && !zero)
      cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      cnt_q <= '0;
    else
      cnt_q <= cnt_d;
  end

  // R7: without a load and without a tick, the count holds
  assert_hold_no_tick_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && !run) |=> $stable(cnt_q));

  // R4: a running, non-zero count steps down by exactly one
  assert_step_down_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && run && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1));
endmodule

// File: rtl/rc_pend.sv
module rc_pend #(
  parameter int N = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set,
  input  logic [N-1:0] clr,
  output logic [N-1:0] pend,
  output logic         irq
);
  logic [N-1:0] pend_d;

  for (genvar i = 0; i < N; i++) begin : g_bit
    always_comb pend_d[i] = set[i] | (pend[i] & ~clr[i]);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        pend[i] <= 1'b0;
      else
        pend[i] <= pend_d[i];
    end

    // R8: a pending bit rises only after its own set condition
    assert_rise_needs_set_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(pend[i]) |-> $past(set[i]));
  end

  assign irq = |pend;
endmodule

// File: rtl/rc_seq.sv
module rc_seq
  import rc_pkg::*;
#(
  parameter int TW = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [LF_W-1:0] lf_cmd,
  input  logic            tick,
  input  logic            ring_trip,
  input  logic            act_run_en,
  input  logic            inact_run_en,
  input  logic [TW-1:0]   act_val,
  input  logic [TW-1:0]   inact_val,
  input  logic            expire,
  output logic            load,
  output logic [TW-1:0]   load_val,
  output logic            run,
  output phase_e          phase,
  output logic [LF_W-1:0] lf_shadow
);
  phase_e          phase_q, phase_d;
  logic [LF_W-1:0] shadow_q, shadow_d;

  always_comb begin
    phase_d  = phase_q;
    shadow_d = shadow_q;
    load     = 1'b0;
    load_val = act_val;
    run      = tick & (((phase_q == PH_BURST) & act_run_en) |
                       ((phase_q == PH_GAP) & inact_run_en));
    if (lf_cmd != LF_RING) begin
      phase_d  = PH_IDLE;
      shadow_d = lf_cmd;
    end else begin
      case (phase_q)
        PH_IDLE: begin
          phase_d  = PH_BURST;
          shadow_d = LF_RING;
          load     = 1'b1;
        end
        PH_BURST: begin
          if (ring_trip) begin
            phase_d  = PH_TRIP;
            shadow_d = LF_ACTIVE;
          end else if (expire) begin
            phase_d  = PH_GAP;
            shadow_d = LF_OHT;
            load     = 1'b1;
            load_val = inact_val;
          end
        end
        PH_GAP: begin
          if (expire) begin
            phase_d  = PH_BURST;
            shadow_d = LF_RING;
            load     = 1'b1;
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q  <= PH_IDLE;
      shadow_q <= LF_OPEN;
    end else begin
      phase_q  <= phase_d;
      shadow_q <= shadow_d;
    end
  end

  assign phase     = phase_q;
  assign lf_shadow = shadow_q;

  // R2, R10: a non-ringing command reaches the shadow one clock later
  assert_follow_cmd_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (lf_cmd != LF_RING) |=> (lf_shadow == $past(lf_cmd)));

  // R3: the burst phase always shows ringing in the shadow
  assert_burst_shows_ring_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_BURST) |-> (lf_shadow == LF_RING));

  // R9: a trip during a burst lands on forward active
  assert_trip_to_active_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (lf_cmd == LF_RING && phase_q == PH_BURST && ring_trip) |=>
      (lf_shadow == LF_ACTIVE && phase_q == PH_TRIP));
endmodule

// File: rtl/ring_cadence_ctrl.sv
module ring_cadence_ctrl
  import rc_pkg::*;
#(
  parameter int TW = 16,
  localparam int BW = TW / 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [2:0]    lf_cmd,
  input  logic          tick,
  input  logic [BW-1:0] act_hi,
  input  logic [BW-1:0] act_lo,
  input  logic [BW-1:0] inact_hi,
  input  logic [BW-1:0] inact_lo,
  input  logic          act_run_en,
  input  logic          inact_run_en,
  input  logic          act_irq_en,
  input  logic          inact_irq_en,
  input  logic          act_pend_clr,
  input  logic          inact_pend_clr,
  input  logic          ring_trip,
  output logic [2:0]    lf_shadow,
  output logic          ring_on,
  output logic          act_pend,
  output logic          inact_pend,
  output logic          irq
);
  logic          load, run, expire;
  logic [TW-1:0] load_val;
  phase_e        phase;
  logic [1:0]    pset, pclr, pend;

  rc_seq #(.TW(TW)) u_seq (
    .clk          (clk),
    .rst_n        (rst_n),
    .lf_cmd       (lf_cmd),
    .tick         (tick),
    .ring_trip    (ring_trip),
    .act_run_en   (act_run_en),
    .inact_run_en (inact_run_en),
    .act_val      ({act_hi, act_lo}),
    .inact_val    ({inact_hi, inact_lo}),
    .expire       (expire),
    .load         (load),
    .load_val     (load_val),
    .run          (run),
    .phase        (phase),
    .lf_shadow    (lf_shadow)
  );

  rc_timer #(.TW(TW)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (load),
    .load_val (load_val),
    .run      (run),
    .expire   (expire)
  );

  assign pset[0] = expire & (phase == PH_BURST) & act_irq_en;
  assign pset[1] = expire & (phase == PH_GAP) & inact_irq_en;
  assign pclr    = {inact_pend_clr, act_pend_clr};

  rc_pend #(.N(2)) u_pend (
    .clk   (clk),
    .rst_n (rst_n),
    .set   (pset),
    .clr   (pclr),
    .pend  (pend),
    .irq   (irq)
  );

  assign act_pend   = pend[0];
  assign inact_pend = pend[1];
  assign ring_on    = (phase == PH_BURST);
endmodule

// File: tb/sim_ring_cadence_ctrl.sv
module sim_ring_cadence_ctrl;
  localparam int CLK_NS = 10;
  localparam int WATCHDOG = 20000;

  logic       clk, rst_n;
  logic [2:0] lf_cmd;
  logic       tick;
  logic [7:0] act_hi, act_lo, inact_hi, inact_lo;
  logic       act_run_en, inact_run_en, act_irq_en, inact_irq_en;
  logic       act_pend_clr, inact_pend_clr, ring_trip;
  logic [2:0] lf_shadow;
  logic       ring_on, act_pend, inact_pend, irq;

  int    tests, fails, cycles;
  int    tick_div;
  string req;
  bit    done;

  int m_ph, m_cnt, m_sh, m_pa, m_pi;

  ring_cadence_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .lf_cmd(lf_cmd), .tick(tick),
    .act_hi(act_hi), .act_lo(act_lo), .inact_hi(inact_hi), .inact_lo(inact_lo),
    .act_run_en(act_run_en), .inact_run_en(inact_run_en),
    .act_irq_en(act_irq_en), .inact_irq_en(inact_irq_en),
    .act_pend_clr(act_pend_clr), .inact_pend_clr(inact_pend_clr),
    .ring_trip(ring_trip), .lf_shadow(lf_shadow), .ring_on(ring_on),
    .act_pend(act_pend), .inact_pend(inact_pend), .irq(irq)
  );

  initial begin
    clk = 1'b0;
    forever #(CLK_NS/2) clk = ~clk;
  end

  // Behavioural reference: phase 0 idle, 1 burst, 2 gap, 3 tripped
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_ph = 0; m_cnt = 0; m_sh = 0; m_pa = 0; m_pi = 0;
    end else begin
      bit run, exp_now;
      run = tick && ((m_ph == 1 && act_run_en) || (m_ph == 2 && inact_run_en));
      exp_now = run && (m_cnt == 0);
      m_pa = ((exp_now && m_ph == 1 && act_irq_en) || (m_pa == 1 && !act_pend_clr)) ? 1 : 0;
      m_pi = ((exp_now && m_ph == 2 && inact_irq_en) || (m_pi == 1 && !inact_pend_clr)) ? 1 : 0;
      if (lf_cmd != 3'b100) begin
        m_ph = 0;
        m_sh = int'(lf_cmd);
      end else if (m_ph == 0) begin
        m_ph = 1; m_sh = 4; m_cnt = int'({act_hi, act_lo});
      end else if (m_ph == 1) begin
        if (ring_trip) begin
          m_ph = 3; m_sh = 1;
        end else if (exp_now) begin
          m_ph = 2; m_sh = 2; m_cnt = int'({inact_hi, inact_lo});
        end else if (run) m_cnt = m_cnt - 1;
      end else if (m_ph == 2) begin
        if (exp_now) begin
          m_ph = 1; m_sh = 4; m_cnt = int'({act_hi, act_lo});
        end else if (run) m_cnt = m_cnt - 1;
      end
    end
  end

  // Per-clock comparison, away from the active edge
  always @(negedge clk) begin
    if (rst_n && !done) begin
      tests++;
      if (lf_shadow !== m_sh[2:0] || ring_on !== (m_ph == 1) ||
          act_pend !== m_pa[0] || inact_pend !== m_pi[0] ||
          irq !== (m_pa[0] | m_pi[0])) begin
        fails++;
        $display("FAIL %s cyc=%0d shadow=%0d/%0d on=%0d/%0d pa=%0d/%0d pi=%0d/%0d irq=%0d/%0d",
                 req, cycles, lf_shadow, m_sh, ring_on, (m_ph == 1), act_pend, m_pa,
                 inact_pend, m_pi, irq, (m_pa | m_pi));
      end
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > WATCHDOG && !done) begin
      done = 1'b1;
      fails++;
      $display("FAIL watchdog expired after %0d cycles (expected completion)", cycles);
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  // Advance n cycles; tick fires every tick_div cycles
  task automatic step(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      tick = (tick_div != 0) && ((cycles % tick_div) == 0);
      ring_trip = 1'b0;
      act_pend_clr = 1'b0;
      inact_pend_clr = 1'b0;
    end
  endtask

  task automatic pulse_trip();
    @(negedge clk);
    ring_trip = 1'b1;
    tick = 1'b0;
    @(negedge clk);
    ring_trip = 1'b0;
  endtask

  initial begin
    tests = 0; fails = 0; cycles = 0; done = 1'b0; tick_div = 1;
    req = "R1";
    rst_n = 1'b0; lf_cmd = 3'b000; tick = 1'b0;
    act_hi = 8'h00; act_lo = 8'h03; inact_hi = 8'h00; inact_lo = 8'h02;
    act_run_en = 1'b1; inact_run_en = 1'b1; act_irq_en = 1'b1; inact_irq_en = 1'b1;
    act_pend_clr = 1'b0; inact_pend_clr = 1'b0; ring_trip = 1'b0;
    repeat (3) @(negedge clk);
    // R1: reset state checked directly
    tests++;
    if (lf_shadow !== 3'b000 || ring_on !== 1'b0 || irq !== 1'b0 ||
        act_pend !== 1'b0 || inact_pend !== 1'b0) begin
      fails++;
      $display("FAIL R1 reset: shadow=%0d on=%0d irq=%0d exp 0 0 0", lf_shadow, ring_on, irq);
    end
    rst_n = 1'b1;
    step(2);

    req = "R2";
    lf_cmd = 3'b001; step(3);
    lf_cmd = 3'b101; step(3);
    lf_cmd = 3'b110; step(3);
    lf_cmd = 3'b010; step(3);

    req = "R3 R4 R5 R8";
    lf_cmd = 3'b100; step(30);
    act_pend_clr = 1'b1; inact_pend_clr = 1'b1; step(1);
    lf_cmd = 3'b001; step(2);

    req = "R7";
    tick_div = 3;
    lf_cmd = 3'b100; step(40);
    lf_cmd = 3'b001; step(2);
    tick_div = 1;

    req = "R6";
    act_run_en = 1'b0;
    lf_cmd = 3'b100; step(25);
    act_run_en = 1'b1; inact_run_en = 1'b0; step(30);
    inact_run_en = 1'b1;
    lf_cmd = 3'b001; step(2);

    req = "R8";
    act_pend_clr = 1'b1; inact_pend_clr = 1'b1; step(1);
    act_irq_en = 1'b0;
    lf_cmd = 3'b100; step(20);
    inact_irq_en = 1'b0; act_irq_en = 1'b1;
    inact_pend_clr = 1'b1; step(20);
    inact_irq_en = 1'b1;
    lf_cmd = 3'b000; step(2);

    req = "R9";
    lf_cmd = 3'b100; step(2);
    pulse_trip();
    step(20);
    lf_cmd = 3'b001; step(2);
    lf_cmd = 3'b100; step(5);
    pulse_trip();
    step(20);
    lf_cmd = 3'b001; step(2);

    req = "R3 R10";
    act_hi = 8'h01; act_lo = 8'h02;
    lf_cmd = 3'b100; step(270);
    lf_cmd = 3'b110; step(3);
    lf_cmd = 3'b100; step(100);
    lf_cmd = 3'b101; step(3);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule